// File: doc/BRIEF.md
# Bus master security filter

This block stands between a single bus master and one downstream memory port and decides, for every access, whether it may proceed and with which security attribute. With each request the master side supplies a security lookup code for the target address. The block combines that code with two static configuration levels: one says whether the master is a non-secure agent, the other selects how violations are answered. The result is one of four outcomes. The block forwards the access marked secure, forwards it marked non-secure, answers it locally as read-as-zero/write-ignored, or answers it locally with an error.

An erroring block also raises a sticky, level-sensitive interrupt toward the system. A clear input drops the interrupt and, while held high, keeps new violations from setting it. One transaction is in flight at a time. Requests and responses use a valid/ready request channel and a single-cycle response pulse on both sides. Accesses of 1, 2, 4 or 8 bytes are carried in the low byte lanes of a little-endian data bus.

Top module: `bus_sec_gate`

## Requirements
- R1: A request whose lookup code is 2'b10 (exempt) is forwarded downstream. `d_req_secure` is 1 when `cfg_master_ns` was 0 at acceptance and 0 when it was 1.
- R2: A request whose lookup code is 2'b01 (non-secure region) is always forwarded with `d_req_secure` = 0, whatever the configuration.
- R3: A request whose lookup code is 2'b00 or 2'b11 (secure region) from a master with `cfg_master_ns` = 0 is forwarded with `d_req_secure` = 1.
- R4: A secure-region request from a master with `cfg_master_ns` = 1 and `cfg_err_resp` = 0 is answered locally. `m_rsp_valid` pulses in the cycle after acceptance with `m_rsp_err` = 0 and `m_rsp_rdata` = 0. `d_req_valid` stays low and the interrupt is not set.
- R5: Under the same conditions with `cfg_err_resp` = 1, `m_rsp_valid` pulses in the cycle after acceptance with `m_rsp_err` = 1, and `d_req_valid` stays low.
- R6: An erroring block accepted while `irq_clr` is low makes `irq` high from the cycle after acceptance until it is cleared. If `irq_clr` is high in the acceptance cycle, `irq` is not set.
- R7: `irq_clr` sampled high at a clock edge makes `irq` low from that edge. This holds even when an erroring block is accepted at the same edge.
- R8: A forwarded access carries address, direction and size (0/1/2/3 = 1/2/4/8 bytes) unchanged. Write data is forwarded with bytes above the access size zeroed. The downstream error flag is returned unchanged. A read returns downstream data with bytes above the access size zeroed, and a write returns zero data.
- R9: `m_req_ready` is low from acceptance until the cycle after the response pulse. While `d_req_valid` is high and `d_req_ready` low, the downstream request and its attribute hold steady.
- R10: Configuration levels are sampled at acceptance; changing them afterwards does not alter that transaction's outcome.
- R11: In reset and right after it, `irq`, `d_req_valid` and `m_rsp_valid` are low and `m_req_ready` is high. Asserting reset clears a set interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master_ns | input | 1 | Master is a non-secure agent |
| cfg_err_resp | input | 1 | Violations answer with error (1) or read-as-zero/write-ignored (0) |
| irq_clr | input | 1 | Interrupt clear, level |
| irq | output | 1 | Violation interrupt, level |
| m_req_valid | input | 1 | Master request valid |
| m_req_ready | output | 1 | Block can accept a request |
| m_req_write | input | 1 | Request is a write |
| m_req_addr | input | 32 | Request address |
| m_req_size | input | 2 | Log2 of access bytes |
| m_req_wdata | input | 64 | Write data, little-endian lanes |
| m_req_lookup | input | 2 | Security lookup code for the address |
| m_rsp_valid | output | 1 | Response pulse to master |
| m_rsp_err | output | 1 | Response error flag |
| m_rsp_rdata | output | 64 | Response read data |
| d_req_valid | output | 1 | Downstream request valid |
| d_req_ready | input | 1 | Downstream accepts request |
| d_req_write | output | 1 | Downstream request is a write |
| d_req_addr | output | 32 | Downstream address |
| d_req_size | output | 2 | Downstream log2 access bytes |
| d_req_wdata | output | 64 | Downstream write data |
| d_req_secure | output | 1 | Security attribute of the forwarded access |
| d_rsp_valid | input | 1 | Downstream response pulse |
| d_rsp_err | input | 1 | Downstream error flag |
| d_rsp_rdata | input | 64 | Downstream read data |

## Verification
An erroring violation and an interrupt clear can land on the same clock edge. The clear must win, and the interrupt must neither be set nor stay set. The sweep accepts every combination of lookup code, configuration, direction and size both with `irq_clr` low and with it held high at the acceptance edge. Some of these happen while the interrupt is already set by an earlier violation. The bench keeps its own model of the sticky bit and compares `irq` in the cycle after each acceptance and after each response.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  typedef enum logic [1:0] {
    LK_SEC     = 2'b00,
    LK_NSEC    = 2'b01,
    LK_EXEMPT  = 2'b10,
    LK_SEC_ALT = 2'b11
  } lookup_e;

  typedef enum logic [1:0] {
    ACT_ABORT  = 2'd0,
    ACT_RAZWI  = 2'd1,
    ACT_FWD_S  = 2'd2,
    ACT_FWD_NS = 2'd3
  } action_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DREQ  = 2'd1,
    ST_DWAIT = 2'd2,
    ST_RSP   = 2'd3
  } state_e;

endpackage

// File: rtl/bsg_verdict.sv
module bsg_verdict
  import bsg_pkg::*;
(
  input  logic [1:0] lookup,
  input  logic       master_ns,
  input  logic       err_resp,
  output action_e    act
);

  always_comb begin
    unique case (lookup)
      LK_EXEMPT: act = master_ns ? ACT_FWD_NS : ACT_FWD_S;
      LK_NSEC:   act = ACT_FWD_NS;
      default: begin
        if (!master_ns)    act = ACT_FWD_S;
        else if (err_resp) act = ACT_ABORT;
        else               act = ACT_RAZWI;
      end
    endcase
  end

endmodule

// File: rtl/bsg_irq.sv
module bsg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic abort_evt,
  input  logic clr,
  output logic irq
);

  logic status_q;
  logic status_d;

  always_comb begin
    if (clr)            status_d = 1'b0;
    else if (abort_evt) status_d = 1'b1;
    else                status_d = status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= status_d;
  end

  assign irq = status_q;

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt && !clr |=> irq); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr |=> irq); // R6
  AST_IRQ_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq); // R7

endmodule

// File: rtl/bsg_seq.sv
module bsg_seq
  import bsg_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 64,
  parameter int SZW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           m_req_valid,
  output logic           m_req_ready,
  input  logic           m_req_write,
  input  logic [AW-1:0]  m_req_addr,
  input  logic [SZW-1:0] m_req_size,
  input  logic [DW-1:0]  m_req_wdata,
  input  action_e        act,
  output logic           m_rsp_valid,
  output logic           m_rsp_err,
  output logic [DW-1:0]  m_rsp_rdata,
  output logic           d_req_valid,
  input  logic           d_req_ready,
  output logic           d_req_write,
  output logic [AW-1:0]  d_req_addr,
  output logic [SZW-1:0] d_req_size,
  output logic [DW-1:0]  d_req_wdata,
  output logic           d_req_secure,
  input  logic           d_rsp_valid,
  input  logic           d_rsp_err,
  input  logic [DW-1:0]  d_rsp_rdata,
  output logic           abort_evt
);

  localparam int NB = DW / 8;

  function automatic logic [DW-1:0] lane_mask(input logic [SZW-1:0] sz);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < (1 << int'(sz))) m[i*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction

  state_e         state_q, state_d;
  logic           accept;
  logic           blocked;
  logic           fwd_done;
  logic           req_en;
  logic           rsp_en;

  logic           write_q;
  logic [AW-1:0]  addr_q;
  logic [SZW-1:0] size_q;
  logic [DW-1:0]  wdata_q;
  logic           secure_q;
  logic           rsp_err_q, rsp_err_d;
  logic [DW-1:0]  rsp_data_q, rsp_data_d;

  assign m_req_ready = (state_q == ST_IDLE);
  assign accept      = m_req_valid && m_req_ready;
  assign blocked     = (act == ACT_ABORT) || (act == ACT_RAZWI);
  assign fwd_done    = (state_q == ST_DWAIT) && d_rsp_valid;
  assign abort_evt   = accept && (act == ACT_ABORT);
  assign req_en      = accept;
  assign rsp_en      = (accept && blocked) || fwd_done;

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (m_req_valid) state_d = blocked ? ST_RSP : ST_DREQ;
      ST_DREQ:  if (d_req_ready) state_d = ST_DWAIT;
      ST_DWAIT: if (d_rsp_valid) state_d = ST_RSP;
      ST_RSP:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // response next values
  always_comb begin
    if (accept) begin
      rsp_err_d  = (act == ACT_ABORT);
      rsp_data_d = '0;
    end else begin
      rsp_err_d  = d_rsp_err;
      rsp_data_d = write_q ? '0 : (d_rsp_rdata & lane_mask(size_q));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q  <= 1'b0;
      addr_q   <= '0;
      size_q   <= '0;
      wdata_q  <= '0;
      secure_q <= 1'b0;
    end else if (req_en) begin
      write_q  <= m_req_write;
      addr_q   <= m_req_addr;
      size_q   <= m_req_size;
      wdata_q  <= m_req_wdata & lane_mask(m_req_size);
      secure_q <= (act == ACT_FWD_S);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_err_q  <= 1'b0;
      rsp_data_q <= '0;
    end else if (rsp_en) begin
      rsp_err_q  <= rsp_err_d;
      rsp_data_q <= rsp_data_d;
    end
  end

  assign m_rsp_valid  = (state_q == ST_RSP);
  assign m_rsp_err    = rsp_err_q;
  assign m_rsp_rdata  = rsp_data_q;
  assign d_req_valid  = (state_q == ST_DREQ);
  assign d_req_write  = write_q;
  assign d_req_addr   = addr_q;
  assign d_req_size   = size_q;
  assign d_req_wdata  = wdata_q;
  assign d_req_secure = secure_q;

  AST_BLOCK_NO_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
    accept && blocked |=> m_rsp_valid && !d_req_valid); // R4
  AST_RAZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (act == ACT_RAZWI) |=> !m_rsp_err && (m_rsp_rdata == '0)); // R4
  AST_ABORT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (act == ACT_ABORT) |=> m_rsp_err); // R5
  AST_DREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    d_req_valid && !d_req_ready |=> d_req_valid && $stable(d_req_addr)
      && $stable(d_req_secure) && $stable(d_req_wdata)); // R9
  AST_FWD_ERR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_done |=> m_rsp_valid && (m_rsp_err == $past(d_rsp_err))); // R8

endmodule

// File: rtl/bus_sec_gate.sv
module bus_sec_gate
  import bsg_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 64,
  parameter int SZW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_master_ns,
  input  logic           cfg_err_resp,
  input  logic           irq_clr,
  output logic           irq,
  input  logic           m_req_valid,
  output logic           m_req_ready,
  input  logic           m_req_write,
  input  logic [AW-1:0]  m_req_addr,
  input  logic [SZW-1:0] m_req_size,
  input  logic [DW-1:0]  m_req_wdata,
  input  logic [1:0]     m_req_lookup,
  output logic           m_rsp_valid,
  output logic           m_rsp_err,
  output logic [DW-1:0]  m_rsp_rdata,
  output logic           d_req_valid,
  input  logic           d_req_ready,
  output logic           d_req_write,
  output logic [AW-1:0]  d_req_addr,
  output logic [SZW-1:0] d_req_size,
  output logic [DW-1:0]  d_req_wdata,
  output logic           d_req_secure,
  input  logic           d_rsp_valid,
  input  logic           d_rsp_err,
  input  logic [DW-1:0]  d_rsp_rdata
);

  logic    rst_meta_q;
  logic    rst_sync_q;
  action_e act;
  logic    abort_evt;
  logic    accept;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  bsg_verdict u_verdict (
    .lookup    (m_req_lookup),
    .master_ns (cfg_master_ns),
    .err_resp  (cfg_err_resp),
    .act       (act)
  );

  bsg_seq #(.AW(AW), .DW(DW), .SZW(SZW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .m_req_valid  (m_req_valid),
    .m_req_ready  (m_req_ready),
    .m_req_write  (m_req_write),
    .m_req_addr   (m_req_addr),
    .m_req_size   (m_req_size),
    .m_req_wdata  (m_req_wdata),
    .act          (act),
    .m_rsp_valid  (m_rsp_valid),
    .m_rsp_err    (m_rsp_err),
    .m_rsp_rdata  (m_rsp_rdata),
    .d_req_valid  (d_req_valid),
    .d_req_ready  (d_req_ready),
    .d_req_write  (d_req_write),
    .d_req_addr   (d_req_addr),
    .d_req_size   (d_req_size),
    .d_req_wdata  (d_req_wdata),
    .d_req_secure (d_req_secure),
    .d_rsp_valid  (d_rsp_valid),
    .d_rsp_err    (d_rsp_err),
    .d_rsp_rdata  (d_rsp_rdata),
    .abort_evt    (abort_evt)
  );

  bsg_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .abort_evt (abort_evt),
    .clr       (irq_clr),
    .irq       (irq)
  );

  assign accept = m_req_valid && m_req_ready;

  AST_NSEC_FWD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    accept && (m_req_lookup == LK_NSEC) |=> d_req_valid && !d_req_secure); // R2
  AST_EXEMPT_ATTR: assert property (@(posedge clk) disable iff (!rst_sync_q)
    accept && (m_req_lookup == LK_EXEMPT) |=>
      d_req_valid && (d_req_secure == !$past(cfg_master_ns))); // R1
  AST_SEC_MASTER_FWD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    accept && !cfg_master_ns && (m_req_lookup inside {LK_SEC, LK_SEC_ALT}) |=>
      d_req_valid && d_req_secure); // R3

endmodule

// File: tb/bus_sec_gate_tb.sv
module bus_sec_gate_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_master_ns, cfg_err_resp, irq_clr;
  logic        irq;
  logic        m_req_valid, m_req_ready, m_req_write;
  logic [31:0] m_req_addr;
  logic [1:0]  m_req_size;
  logic [63:0] m_req_wdata;
  logic [1:0]  m_req_lookup;
  logic        m_rsp_valid, m_rsp_err;
  logic [63:0] m_rsp_rdata;
  logic        d_req_valid, d_req_ready, d_req_write;
  logic [31:0] d_req_addr;
  logic [1:0]  d_req_size;
  logic [63:0] d_req_wdata;
  logic        d_req_secure;
  logic        d_rsp_valid, d_rsp_err;
  logic [63:0] d_rsp_rdata;

  int total = 0;
  int fails = 0;
  int cyc   = 0;
  logic exp_irq = 1'b0;

  bus_sec_gate u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_master_ns(cfg_master_ns), .cfg_err_resp(cfg_err_resp),
    .irq_clr(irq_clr), .irq(irq),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
    .m_req_write(m_req_write), .m_req_addr(m_req_addr),
    .m_req_size(m_req_size), .m_req_wdata(m_req_wdata),
    .m_req_lookup(m_req_lookup),
    .m_rsp_valid(m_rsp_valid), .m_rsp_err(m_rsp_err), .m_rsp_rdata(m_rsp_rdata),
    .d_req_valid(d_req_valid), .d_req_ready(d_req_ready),
    .d_req_write(d_req_write), .d_req_addr(d_req_addr),
    .d_req_size(d_req_size), .d_req_wdata(d_req_wdata),
    .d_req_secure(d_req_secure),
    .d_rsp_valid(d_rsp_valid), .d_rsp_err(d_rsp_err), .d_rsp_rdata(d_rsp_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic wr, input logic [1:0] lk, input logic cns,
                         input logic cer, input logic clr, input logic [1:0] sz,
                         input int idx);
    logic [63:0] wd, mk, rd, exp_rd;
    logic [31:0] ad;
    logic        sec_exp, blk, abt, derr;
    int          lat;
    string       tg;
    wd  = {32'hA5C3_0F1E ^ 32'(idx), 32'h1234_5678 + 32'(idx)};
    ad  = 32'h1000_0000 + 32'(idx * 8);
    rd  = 64'hFEDC_BA98_7654_3210 ^ {32'(idx), 32'(idx * 3)};
    mk  = '0;
    for (int i = 0; i < 8; i++) if (i < (1 << int'(sz))) mk[i*8 +: 8] = 8'hFF;
    blk = ((lk == 2'b00) || (lk == 2'b11)) && cns;
    abt = blk && cer;
    sec_exp = (lk == 2'b10) ? !cns : ((lk == 2'b01) ? 1'b0 : 1'b1);
    tg  = (lk == 2'b10) ? "R1" : ((lk == 2'b01) ? "R2" : "R3");
    derr = ((idx / 4) % 2) == 1;
    lat  = idx % 3;
    exp_rd = wr ? 64'h0 : (rd & mk);

    @(negedge clk);
    chk(m_req_ready == 1'b1, "R9 ready idle", {63'h0, m_req_ready}, 64'h1);
    m_req_valid = 1'b1; m_req_write = wr; m_req_addr = ad; m_req_size = sz;
    m_req_wdata = wd; m_req_lookup = lk;
    cfg_master_ns = cns; cfg_err_resp = cer; irq_clr = clr;

    @(negedge clk);
    m_req_valid = 1'b0;
    cfg_master_ns = ~cns; cfg_err_resp = ~cer;   // R10: change after acceptance
    if (clr) exp_irq = 1'b0;
    else if (abt) exp_irq = 1'b1;
    chk(irq == exp_irq, clr ? "R7 clear at accept" : "R6 irq after accept",
        {63'h0, irq}, {63'h0, exp_irq});
    irq_clr = 1'b0;
    chk(m_req_ready == 1'b0, "R9 ready low busy", {63'h0, m_req_ready}, 64'h0);

    if (blk) begin
      chk(m_rsp_valid == 1'b1, abt ? "R5 rsp pulse" : "R4 rsp pulse",
          {63'h0, m_rsp_valid}, 64'h1);
      chk(d_req_valid == 1'b0, abt ? "R5 no dreq" : "R4 no dreq",
          {63'h0, d_req_valid}, 64'h0);
      chk(m_rsp_err == abt, abt ? "R5 err" : "R4 ok resp",
          {63'h0, m_rsp_err}, {63'h0, abt});
      if (!abt) chk(m_rsp_rdata == 64'h0, "R4 zero data", m_rsp_rdata, 64'h0);
    end else begin
      chk(d_req_valid == 1'b1, tg, {63'h0, d_req_valid}, 64'h1);
      chk(d_req_secure == sec_exp, tg, {63'h0, d_req_secure}, {63'h0, sec_exp});
      chk(d_req_secure == sec_exp, "R10 attr kept", {63'h0, d_req_secure}, {63'h0, sec_exp});
      chk(d_req_addr == ad, "R8 addr", {32'h0, d_req_addr}, {32'h0, ad});
      chk(d_req_write == wr && d_req_size == sz, "R8 dir size",
          {61'h0, d_req_write, d_req_size}, {61'h0, wr, sz});
      chk(d_req_wdata == (wd & mk), "R8 wdata", d_req_wdata, wd & mk);
      chk(m_rsp_valid == 1'b0, "R9 no early rsp", {63'h0, m_rsp_valid}, 64'h0);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk(d_req_valid == 1'b1 && d_req_addr == ad && d_req_secure == sec_exp,
            "R9 hold", {31'h0, d_req_valid, d_req_addr}, {31'h0, 1'b1, ad});
      end
      d_req_ready = 1'b1;
      @(negedge clk);
      d_req_ready = 1'b0;
      chk(d_req_valid == 1'b0 && m_rsp_valid == 1'b0, "R9 wait",
          {62'h0, d_req_valid, m_rsp_valid}, 64'h0);
      d_rsp_valid = 1'b1; d_rsp_err = derr; d_rsp_rdata = rd;
      @(negedge clk);
      d_rsp_valid = 1'b0;
      chk(m_rsp_valid == 1'b1, "R8 rsp pulse", {63'h0, m_rsp_valid}, 64'h1);
      chk(m_rsp_err == derr, "R8 err pass", {63'h0, m_rsp_err}, {63'h0, derr});
      chk(m_rsp_rdata == exp_rd, "R8 rdata", m_rsp_rdata, exp_rd);
    end

    @(negedge clk);
    chk(m_rsp_valid == 1'b0 && m_req_ready == 1'b1, "R9 back idle",
        {62'h0, m_rsp_valid, m_req_ready}, 64'h1);
    chk(irq == exp_irq, "R6 irq sticky", {63'h0, irq}, {63'h0, exp_irq});
  endtask

  task automatic clear_irq();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    exp_irq = 1'b0;
    chk(irq == 1'b0, "R7 clear", {63'h0, irq}, 64'h0);
  endtask

  initial begin
    int idx;
    rst_n = 1'b0;
    cfg_master_ns = 0; cfg_err_resp = 0; irq_clr = 0;
    m_req_valid = 0; m_req_write = 0; m_req_addr = '0; m_req_size = '0;
    m_req_wdata = '0; m_req_lookup = '0;
    d_req_ready = 0; d_rsp_valid = 0; d_rsp_err = 0; d_rsp_rdata = '0;
    repeat (3) @(negedge clk);
    chk(irq == 0 && d_req_valid == 0 && m_rsp_valid == 0, "R11 in reset",
        {61'h0, irq, d_req_valid, m_rsp_valid}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(m_req_ready == 1'b1 && irq == 1'b0, "R11 after reset",
        {62'h0, m_req_ready, irq}, 64'h2);

    idx = 0;
    for (int w = 0; w < 2; w++)
      for (int l = 0; l < 4; l++)
        for (int n = 0; n < 2; n++)
          for (int e = 0; e < 2; e++)
            for (int c = 0; c < 2; c++)
              for (int s = 0; s < 4; s++) begin
                run_txn(w[0], l[1:0], n[0], e[0], c[0], s[1:0], idx);
                idx = idx + 1;
                if (idx % 16 == 5) clear_irq();
              end

    // set the interrupt, then reset asynchronously
    run_txn(1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 2'd3, 999);
    chk(irq == 1'b1, "R6 set before reset", {63'h0, irq}, 64'h1);
    #1 rst_n = 1'b0;
    #1 chk(irq == 1'b0, "R11 reset clears irq", {63'h0, irq}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(m_req_ready == 1'b1 && irq == 1'b0, "R11 ready after reset",
        {62'h0, m_req_ready, irq}, 64'h2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule